// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between an on-chip requester and an external asynchronous static RAM of 32768 words by 8 bits. The requester hands over one word at a time through a valid/ready handshake carrying an address, a write flag and write data. The controller then runs a complete memory cycle on the pins: a 15-bit address, three active-low strobes (select, read output enable, write) and an 8-bit data path. The data path is split into output value, output enable and input value, for connection to a bidirectional pad. Read results come back on `rd_data`, marked by a one-cycle `rd_valid` pulse.

Every phase of a memory cycle lasts a whole number of clock cycles. Each count is ceil(limit / CLK_NS), and never less than one. CLK_NS is the clock period in ns, and the limits are the nanosecond minimums and maximums of the memory's speed grade. The strobes are sequenced so that the controller and the memory never drive the data lines at the same time. When a write follows a read, an idle gap long enough for the memory to release its outputs is placed before the controller drives.

Top module: `sramc_top`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `sram_sel_n`, `sram_read_n` and `sram_write_n` are 1, `sram_dout_en` and `rd_valid` are 0, and `req_ready` is 1.
- R2: `req_ready` is 1 only when no memory cycle is in progress. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is then 0 until that cycle has ended.
- R3: A read holds `sram_sel_n`=0, `sram_read_n`=0 and `sram_write_n`=1 for exactly N_RD cycles, with `sram_addr` stable. N_RD is the largest of ceil(55/CLK_NS), ceil(30/CLK_NS) and ceil(55/CLK_NS), which is 11 at CLK_NS=5.
- R4: `sram_din` is registered on the edge that ends the read strobes. In the next cycle `rd_valid` is 1 for exactly one cycle, and `rd_data` holds the word stored at the requested address.
- R5: A write holds `sram_sel_n`=0 with `sram_write_n`=1 for one setup cycle. It then holds `sram_write_n`=0 for N_WP cycles, which is 9 at CLK_NS=5. N_WP is the largest of ceil(45/CLK_NS), ceil(25/CLK_NS), ceil(50/CLK_NS)-1 and ceil(55/CLK_NS)-2. `sram_read_n` stays 1 for the whole write, and the address and data are stable.
- R6: `sram_dout_en` is 1 only during the setup and pulse of a write, so it is 1 in every cycle with `sram_write_n`=0. It falls on the same edge on which `sram_write_n` and `sram_sel_n` rise.
- R7: `sram_dout_en` is never 1 in a cycle in which `sram_read_n` is 0.
- R8: After a read, the next accepted write waits N_TA = ceil(20/CLK_NS) idle cycles (4 at CLK_NS=5) before its setup. `sram_sel_n` therefore falls N_TA+1 cycles after the accepting edge.
- R9: A read is never delayed by a turnaround. Neither is a write whose previous operation was a write, or a write that is the first operation after reset. In these cases `sram_sel_n` falls in the first cycle after the accepting edge.
- R10: A word written to an address is returned by every later read of that address until that address is written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | One-cycle pulse: rd_data is valid |
| rd_data | output | 8 | Data returned by a read |
| sram_addr | output | 15 | Memory address pins |
| sram_sel_n | output | 1 | Memory select, active low |
| sram_read_n | output | 1 | Memory output enable, active low |
| sram_write_n | output | 1 | Memory write strobe, active low |
| sram_dout | output | 8 | Data toward the pad |
| sram_dout_en | output | 1 | Pad driver enable, active high |
| sram_din | input | 8 | Data from the pad |

## Verification
The bench's memory model returns a garbage byte until the access time has passed, so a capture taken one cycle early is caught. The model also flags any cycle in which both sides drive the data lines. Directed sequences cover four orders, each of which separates one latency rule: write then read, read then write, write then write, and read then read. Random mixes that often reuse a small set of addresses check that read-back matches the last write. Random addresses spread across the full range check the address path.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

    // Speed-grade limits in ns
    localparam int unsigned LIM_ADDR_ACC = 55;
    localparam int unsigned LIM_OE_ACC   = 30;
    localparam int unsigned LIM_RD_CYC   = 55;
    localparam int unsigned LIM_WR_PULSE = 45;
    localparam int unsigned LIM_SEL_WR   = 50;
    localparam int unsigned LIM_DSETUP   = 25;
    localparam int unsigned LIM_WR_CYC   = 55;
    localparam int unsigned LIM_RELEASE  = 20;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACCESS,
        ST_RD_CAPTURE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_RELEASE,
        ST_TURNAROUND
    } ctl_state_e;

    typedef struct packed {
        logic sel_n;
        logic read_n;
        logic write_n;
        logic drive;
    } pin_ctl_t;

    localparam pin_ctl_t PINS_QUIET = '{sel_n: 1'b1, read_n: 1'b1, write_n: 1'b1, drive: 1'b0};

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Cycles covering a limit, never fewer than one
    function automatic int unsigned phase_cycles(input int unsigned lim_ns, input int unsigned clk_ns);
        int unsigned c;
        c = (lim_ns + clk_ns - 1) / clk_ns;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned sub_floor1(input int unsigned a, input int unsigned b);
        return (a > b) ? (a - b) : 1;
    endfunction

    function automatic pin_ctl_t pins_for(input ctl_state_e st);
        pin_ctl_t p;
        p = PINS_QUIET;
        case (st)
            ST_RD_ACCESS: begin p.sel_n = 1'b0; p.read_n = 1'b0; end
            ST_WR_SETUP:  begin p.sel_n = 1'b0; p.drive = 1'b1; end
            ST_WR_PULSE:  begin p.sel_n = 1'b0; p.write_n = 1'b0; p.drive = 1'b1; end
            default:      p = PINS_QUIET;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sramc_phase_timer.sv
module sramc_phase_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sramc_seq.sv
module sramc_seq
    import sramc_pkg::*;
#(
    parameter int unsigned N_RD  = 6,
    parameter int unsigned N_WP  = 5,
    parameter int unsigned N_TA  = 2,
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             expired,
    output logic             req_ready,
    output logic             accept,
    output logic             capture,
    output logic             load,
    output logic [CNT_W-1:0] load_val,
    output pin_ctl_t         pins,
    output logic             rd_valid
);
    ctl_state_e state_q, state_d;
    logic       after_read_q;
    pin_ctl_t   pins_q;
    logic       rd_valid_q;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_ready && req_valid;
    assign capture   = (state_q == ST_RD_ACCESS) && expired;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (req_valid) begin
                if (!req_write)       state_d = ST_RD_ACCESS;
                else if (after_read_q) state_d = ST_TURNAROUND;
                else                  state_d = ST_WR_SETUP;
            end
            ST_RD_ACCESS:  if (expired) state_d = ST_RD_CAPTURE;
            ST_RD_CAPTURE: state_d = ST_IDLE;
            ST_TURNAROUND: if (expired) state_d = ST_WR_SETUP;
            ST_WR_SETUP:   state_d = ST_WR_PULSE;
            ST_WR_PULSE:   if (expired) state_d = ST_WR_RELEASE;
            ST_WR_RELEASE: state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // Timer is loaded on entry to each counted phase
    always_comb begin
        load     = 1'b0;
        load_val = '0;
        if (state_d != state_q) begin
            case (state_d)
                ST_RD_ACCESS:  begin load = 1'b1; load_val = CNT_W'(N_RD - 1); end
                ST_WR_PULSE:   begin load = 1'b1; load_val = CNT_W'(N_WP - 1); end
                ST_TURNAROUND: begin load = 1'b1; load_val = CNT_W'(N_TA - 1); end
                default:       begin load = 1'b0; load_val = '0; end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            after_read_q <= 1'b0;
            pins_q       <= PINS_QUIET;
            rd_valid_q   <= 1'b0;
        end else begin
            state_q    <= state_d;
            pins_q     <= pins_for(state_d);
            rd_valid_q <= (state_d == ST_RD_CAPTURE);
            if (state_d == ST_RD_ACCESS)
                after_read_q <= 1'b1;
            else if (state_d == ST_WR_SETUP)
                after_read_q <= 1'b0;
        end
    end

    assign pins     = pins_q;
    assign rd_valid = rd_valid_q;
endmodule

// File: rtl/sramc_datapath.sv
module sramc_datapath #(
    parameter int unsigned ADDR_W = 15,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] pad_in,
    output logic [ADDR_W-1:0] pad_addr,
    output logic [DATA_W-1:0] pad_out,
    output logic [DATA_W-1:0] rd_data
);
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (capture)
                rdata_q <= pad_in;
        end
    end

    assign pad_addr = addr_q;
    assign pad_out  = wdata_q;
    assign rd_data  = rdata_q;
endmodule

// File: rtl/sramc_top.sv
module sramc_top
    import sramc_pkg::*;
#(
    parameter int unsigned ADDR_W   = 15,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned CLK_NS   = 10,
    parameter int unsigned T_AA_NS  = LIM_ADDR_ACC,
    parameter int unsigned T_OA_NS  = LIM_OE_ACC,
    parameter int unsigned T_RC_NS  = LIM_RD_CYC,
    parameter int unsigned T_WP_NS  = LIM_WR_PULSE,
    parameter int unsigned T_SW_NS  = LIM_SEL_WR,
    parameter int unsigned T_DS_NS  = LIM_DSETUP,
    parameter int unsigned T_WC_NS  = LIM_WR_CYC,
    parameter int unsigned T_REL_NS = LIM_RELEASE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_sel_n,
    output logic              sram_read_n,
    output logic              sram_write_n,
    output logic [DATA_W-1:0] sram_dout,
    output logic              sram_dout_en,
    input  logic [DATA_W-1:0] sram_din
);
    localparam int unsigned N_RD = max2(max2(phase_cycles(T_AA_NS, CLK_NS),
                                             phase_cycles(T_OA_NS, CLK_NS)),
                                        phase_cycles(T_RC_NS, CLK_NS));
    // Select is also low during the one setup cycle; release adds one more
    localparam int unsigned N_WP = max2(max2(phase_cycles(T_WP_NS, CLK_NS),
                                             phase_cycles(T_DS_NS, CLK_NS)),
                                        max2(sub_floor1(phase_cycles(T_SW_NS, CLK_NS), 1),
                                             sub_floor1(phase_cycles(T_WC_NS, CLK_NS), 2)));
    localparam int unsigned N_TA  = phase_cycles(T_REL_NS, CLK_NS);
    localparam int unsigned N_MAX = max2(max2(N_RD, N_WP), N_TA);
    localparam int unsigned CNT_W = (N_MAX < 2) ? 1 : $clog2(N_MAX);

    logic             accept, capture, load, expired;
    logic [CNT_W-1:0] load_val;
    pin_ctl_t         pins;

    sramc_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    sramc_seq #(.N_RD(N_RD), .N_WP(N_WP), .N_TA(N_TA), .CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .expired   (expired),
        .req_ready (req_ready),
        .accept    (accept),
        .capture   (capture),
        .load      (load),
        .load_val  (load_val),
        .pins      (pins),
        .rd_valid  (rd_valid)
    );

    sramc_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .capture   (capture),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .pad_in    (sram_din),
        .pad_addr  (sram_addr),
        .pad_out   (sram_dout),
        .rd_data   (rd_data)
    );

    assign sram_sel_n   = pins.sel_n;
    assign sram_read_n  = pins.read_n;
    assign sram_write_n = pins.write_n;
    assign sram_dout_en = pins.drive;
endmodule

// File: rtl/sramc_chk.sv
module sramc_chk #(
    parameter int unsigned ADDR_W = 15,
    parameter int unsigned N_RD   = 6,
    parameter int unsigned N_WP   = 5,
    parameter int unsigned N_TA   = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              sram_sel_n,
    input logic              sram_read_n,
    input logic              sram_write_n,
    input logic              sram_dout_en
);
    logic [15:0] rd_run, wr_run, quiet_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_run    <= '0;
            wr_run    <= '0;
            quiet_run <= 16'hFFFF;
        end else begin
            rd_run <= !sram_read_n ? rd_run + 16'd1 : 16'd0;
            wr_run <= !sram_write_n ? wr_run + 16'd1 : 16'd0;
            if (!sram_read_n)
                quiet_run <= '0;
            else if (quiet_run != 16'hFFFF)
                quiet_run <= quiet_run + 16'd1;
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk) rst |=>
        (sram_sel_n && sram_read_n && sram_write_n && !sram_dout_en && !rd_valid && req_ready));

    p_ready_idle_r2: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (sram_sel_n && sram_read_n && sram_write_n && !sram_dout_en));

    p_read_len_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_read_n) |-> (rd_run == 16'(N_RD)));

    p_addr_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!sram_sel_n && !$past(sram_sel_n)) |-> $stable(sram_addr));

    p_valid_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    p_write_len_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_write_n) |-> (wr_run == 16'(N_WP)));

    p_write_pins_r6: assert property (@(posedge clk) disable iff (rst)
        !sram_write_n |-> (sram_read_n && !sram_sel_n && sram_dout_en));

    p_release_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_write_n) |-> (sram_sel_n && !sram_dout_en));

    p_no_fight_r7: assert property (@(posedge clk) disable iff (rst)
        !sram_read_n |-> !sram_dout_en);

    p_turnaround_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_dout_en) |-> (quiet_run >= 16'(N_TA)));
endmodule

bind sramc_top sramc_chk #(.ADDR_W(ADDR_W), .N_RD(N_RD), .N_WP(N_WP), .N_TA(N_TA)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_ready    (req_ready),
    .rd_valid     (rd_valid),
    .sram_addr    (sram_addr),
    .sram_sel_n   (sram_sel_n),
    .sram_read_n  (sram_read_n),
    .sram_write_n (sram_write_n),
    .sram_dout_en (sram_dout_en)
);

// File: tb/sramc_top_tb_top.sv
`timescale 1ns/1ps
module sramc_top_tb_top;
    localparam int CLK = 5;
    localparam int AW  = 15;
    localparam int DW  = 8;

    function automatic int cyc(input int lim);
        int c;
        c = (lim + CLK - 1) / CLK;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int E_RD = 11;  // max(55,30,55 ns) at 5 ns
    localparam int E_WP = 9;   // max(45, 25, 50 ns-1 cycle, 55 ns-2 cycles)
    localparam int E_TA = 4;   // 20 ns

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rd_valid;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] sram_addr;
    logic          sram_sel_n, sram_read_n, sram_write_n, sram_dout_en;
    logic [DW-1:0] sram_dout;
    logic [DW-1:0] sram_din;

    int checks = 0;
    int errors = 0;
    int cycle  = 0;

    always #2.5 clk = ~clk;

    sramc_top #(.CLK_NS(CLK)) dut_i (
        .clk (clk), .rst (rst),
        .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
        .req_addr (req_addr), .req_wdata (req_wdata),
        .rd_valid (rd_valid), .rd_data (rd_data),
        .sram_addr (sram_addr), .sram_sel_n (sram_sel_n), .sram_read_n (sram_read_n),
        .sram_write_n (sram_write_n), .sram_dout (sram_dout), .sram_dout_en (sram_dout_en),
        .sram_din (sram_din)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cycle);
        end
    endtask

    // ---------------- memory model ----------------
    logic [DW-1:0] model_mem [int];
    logic [DW-1:0] ref_mem   [int];
    int            acc_cnt = 0;
    logic          wr_pend = 1'b0;
    logic [AW-1:0] pend_addr;
    logic [DW-1:0] pend_data;
    logic          prev_sel_n = 1'b1;
    logic [AW-1:0] prev_addr;
    int            rd_run = 0, wr_run = 0;

    function automatic logic [DW-1:0] init_word(input logic [AW-1:0] a);
        return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h5A;
    endfunction

    function automatic logic [DW-1:0] model_word(input logic [AW-1:0] a);
        return model_mem.exists(int'(a)) ? model_mem[int'(a)] : init_word(a);
    endfunction

    function automatic logic [DW-1:0] exp_word(input logic [AW-1:0] a);
        return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : init_word(a);
    endfunction

    wire model_drive = !sram_sel_n && !sram_read_n && sram_write_n;
    assign sram_din = (model_drive && acc_cnt >= cyc(55) && acc_cnt >= cyc(30))
                      ? model_word(sram_addr) : 8'hEE;

    always @(negedge clk) begin
        cycle++;
        if (!rst) begin
            acc_cnt = model_drive ? acc_cnt + 1 : 0;
            // R7: both sides never drive together
            if (model_drive && sram_dout_en)
                chk(1'b0, "R7 contention", 1, 0);
            // R5/R6: pins during write pulse
            if (!sram_write_n) begin
                chk(sram_dout_en && sram_read_n && !sram_sel_n, "R6 drive during write pulse",
                    {sram_dout_en, sram_read_n, sram_sel_n}, 3'b110);
                wr_pend   = 1'b1;
                pend_addr = sram_addr;
                pend_data = sram_dout;
                wr_run++;
            end else if (wr_pend) begin
                chk(wr_run == E_WP, "R5 write pulse length", wr_run, E_WP);
                chk(!sram_dout_en && sram_sel_n, "R6 release with strobe", sram_dout_en, 0);
                model_mem[int'(pend_addr)] = pend_data;
                wr_pend = 1'b0;
                wr_run  = 0;
            end
            if (!sram_read_n) rd_run++;
            else if (rd_run != 0) begin
                chk(rd_run == E_RD, "R3 read strobe length", rd_run, E_RD);
                rd_run = 0;
            end
            if (!sram_sel_n && !prev_sel_n && sram_addr != prev_addr)
                chk(1'b0, "R3 address stable while selected", int'(sram_addr), int'(prev_addr));
            prev_sel_n = sram_sel_n;
            prev_addr  = sram_addr;
        end
    end

    // ---------------- request driver ----------------
    bit last_read = 1'b0;

    task automatic do_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
        int lat, exp_lat, wait_v;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_write = $urandom; req_addr = $urandom; req_wdata = $urandom;
        chk(!req_ready, "R2 ready low while busy", req_ready, 0);
        lat = 1;
        while (sram_sel_n && lat < 50) begin @(negedge clk); lat++; end
        exp_lat = (wr && last_read) ? E_TA + 1 : 1;
        if (wr && last_read) chk(lat == exp_lat, "R8 turnaround before write", lat, exp_lat);
        else                 chk(lat == exp_lat, "R9 no extra delay", lat, exp_lat);
        if (wr) begin
            ref_mem[int'(a)] = d;
            while (!req_ready) @(negedge clk);
        end else begin
            wait_v = 0;
            while (!rd_valid && wait_v < 60) begin @(negedge clk); wait_v++; end
            chk(rd_valid && rd_data == exp_word(a), "R4/R10 read data",
                int'(rd_data), int'(exp_word(a)));
            @(negedge clk);
            chk(!rd_valid, "R4 single valid pulse", rd_valid, 0);
        end
        last_read = !wr;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int r;
        logic [AW-1:0] a;
        r = $urandom(32'h5EED_0017);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(sram_sel_n && sram_read_n && sram_write_n && !sram_dout_en && !rd_valid && req_ready,
            "R1 state in reset", {sram_sel_n, sram_read_n, sram_write_n, sram_dout_en, rd_valid, req_ready},
            6'b111001);
        rst = 1'b0;
        @(negedge clk);
        chk(sram_sel_n && sram_read_n && sram_write_n && !sram_dout_en && !rd_valid && req_ready,
            "R1 state after reset", {sram_sel_n, sram_read_n, sram_write_n, sram_dout_en, rd_valid, req_ready},
            6'b111001);

        // directed orders
        do_op(1'b0, 15'h0123, 8'h00);   // read of untouched word, R10 initial content
        do_op(1'b0, 15'h7FFF, 8'h00);   // read after read
        do_op(1'b1, 15'h7FFF, 8'hC3);   // write after read: R8
        do_op(1'b1, 15'h0000, 8'h3C);   // write after write: R9
        do_op(1'b0, 15'h7FFF, 8'h00);   // read after write: R9, R10
        do_op(1'b0, 15'h0000, 8'h00);
        do_op(1'b1, 15'h0000, 8'hFF);   // overwrite
        do_op(1'b0, 15'h0000, 8'h00);   // R10 latest value wins

        for (int i = 0; i < 300; i++) begin
            r = $urandom;
            a = r[1] ? AW'(r[4:2]) : r[18:4];
            do_op(r[0], a, r[26:19]);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule